// File: doc/BRIEF.md
# Memory Bandwidth Monitor

This block observes a memory arbiter that serves 48 requesting ports: 32 major ports, plus 16 device subports that share major slot 23. Each clock it looks at the per-port request and grant vectors. It keeps saturating counts of cycles with any request, cycles with any grant, and cycles in which a grant matches each of four programmable channel filters. A channel filter is a 32-bit major-port mask combined with a 16-bit subport mask. The subport mask applies only when the channel routes to the shared device slot.

Software programs the block through a word-addressed read/write bus. In free-running mode the count registers show the live counters. In timer mode a down-counter defines measurement windows. At each window end the live counts are frozen into readable copies, the live counters restart, and an interrupt flag is raised. Software clears the flag by writing the control word back.

Top module: `bw_monitor`

## Requirements
- R1: After reset every register reads 0 and `irq` is low. Control word (offset 0x00) layout: bit 31 global enable, bit 30 window-done flag, bit 20 timer mode, bits 3:0 enable channels 0..3; all other bits read 0.
- R2: `bus_rdata` is registered and holds the word addressed by `bus_addr[5:2]` in the cycle after `bus_rd`. Channel n port mask sits at 0x04+8n and its subport mask (16 bits, upper bits read 0) at 0x08+8n; the window reload sits at 0x3C.
- R3: The count at 0x24 adds one for each enabled cycle with any request bit set; the count at 0x28 adds one for each enabled cycle with any grant bit set.
- R4: Channel n (count at 0x2C+4n) adds at most one per cycle when a grant on a port p below 32 has port-mask bit p set.
- R5: Global ports 32..47 are device subports 0..15; a grant on one counts for channel n when port-mask bit 23 and the matching subport-mask bit are both set.
- R6: Counters saturate at all ones (255 with an 8-bit counter) instead of wrapping.
- R7: Nothing counts while bit 31 is clear; a channel with its enable bit clear, or with both filter registers zero, never counts.
- R8: In timer mode the down-counter holds the reload value while idle. While active it decrements each clock. On the clock it is zero, the live counts are copied to the readable copies, the live counters restart with that clock's events (so a grant on the ending clock belongs to the new window), and the reload value is taken again. With continuous traffic the first window therefore holds reload events and later windows hold reload+1.
- R9: The flag (bit 30) sets at a window end and clears on a control write with bit 30 set; a window end on the same clock wins.
- R10: `irq` is a registered copy of flag AND global enable, one clock behind.
- R11: Any write to a count register clears both its live and readable value, whatever the data.
- R12: Count registers read the frozen copies in timer mode and the live counters otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| port_req | input | 48 | Per-port request pulses |
| port_gnt | input | 48 | Per-port grant pulses |
| irq | output | 1 | Window-done interrupt |

## Verification
The bench builds the monitor with 8-bit counters and a 16-bit window timer. This puts counter saturation within a few hundred cycles, and lets short windows roll over many times inside a few thousand cycles. The directed part pins the first-window length against the later window length, and the flag clear. A random phase then mixes filter, reload and control writes with sparse traffic, and compares every read and the interrupt against a cycle model kept in the bench.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
  localparam int unsigned DW       = 32;
  localparam int unsigned AW       = 6;
  localparam int unsigned WW       = AW - 2;
  localparam int unsigned MAJ      = 32;
  localparam int unsigned SUB      = 16;
  localparam int unsigned NPORT    = MAJ + SUB;
  localparam int unsigned NCH      = 4;
  localparam int unsigned NCNT     = 2 + NCH;
  localparam int unsigned DEV_SLOT = 23;

  // word indices of the register map
  localparam int unsigned W_CTRL  = 0;
  localparam int unsigned W_FILT0 = 1;
  localparam int unsigned W_CNT0  = 9;
  localparam int unsigned W_TMR   = 15;

  // control word bit positions
  localparam int unsigned B_EN    = 31;
  localparam int unsigned B_FLAG  = 30;
  localparam int unsigned B_TMODE = 20;

  // one channel's grant match for this clock
  function automatic logic chan_hit(input logic [NPORT-1:0] gnt,
                                    input logic [MAJ-1:0]   pmask,
                                    input logic [SUB-1:0]   smask);
    logic major_hit, dev_hit;
    major_hit = |(gnt[MAJ-1:0] & pmask);
    dev_hit   = pmask[DEV_SLOT] & (|(gnt[NPORT-1:MAJ] & smask));
    return major_hit | dev_hit;
  endfunction
endpackage

// File: rtl/bwm_regs.sv
module bwm_regs
  import bwm_pkg::*;
#(
  parameter int unsigned TMR_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [AW-1:0]             addr,
  input  logic [DW-1:0]             wdata,
  input  logic                      win_end,
  output logic                      mon_en,
  output logic                      tmode,
  output logic                      flag,
  output logic [NCH-1:0]            ch_en,
  output logic [NCH-1:0][MAJ-1:0]   pmask,
  output logic [NCH-1:0][SUB-1:0]   smask,
  output logic [TMR_W-1:0]          reload,
  output logic [NCNT-1:0]           cnt_clr
);
  logic [WW-1:0] word;
  logic          wr_ctrl, wr_tmr, flag_clr;
  logic          bus_unused;

  assign word       = addr[AW-1:2];
  assign bus_unused = ^{addr[1:0], wdata};
  assign wr_ctrl    = wr_en && (word == WW'(W_CTRL));
  assign wr_tmr     = wr_en && (word == WW'(W_TMR));
  assign flag_clr   = wr_ctrl && wdata[B_FLAG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mon_en <= 1'b0;
      tmode  <= 1'b0;
      ch_en  <= '0;
    end else if (wr_ctrl) begin
      mon_en <= wdata[B_EN];
      tmode  <= wdata[B_TMODE];
      ch_en  <= wdata[NCH-1:0];
    end
  end

  // a window end on the same clock beats the software clear
  always_ff @(posedge clk) begin
    if (!rst_n)        flag <= 1'b0;
    else if (win_end)  flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pmask <= '0;
      smask <= '0;
    end else if (wr_en) begin
      for (int n = 0; n < NCH; n++) begin
        if (word == WW'(W_FILT0 + 2 * n))     pmask[n] <= wdata[MAJ-1:0];
        if (word == WW'(W_FILT0 + 2 * n + 1)) smask[n] <= wdata[SUB-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reload <= '0;
    else if (wr_tmr) reload <= wdata[TMR_W-1:0];
  end

  for (genvar i = 0; i < NCNT; i++) begin : g_clr
    assign cnt_clr[i] = wr_en && (word == WW'(W_CNT0 + i));
  end
endmodule

// File: rtl/bwm_window.sv
module bwm_window #(
  parameter int unsigned TMR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [TMR_W-1:0] reload,
  output logic             win_end
);
  logic [TMR_W-1:0] tmr;

  assign win_end = active && (tmr == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)               tmr <= '0;
    else if (!active)         tmr <= reload;
    else if (tmr == '0)       tmr <= reload;
    else                      tmr <= tmr - TMR_W'(1);
  end
endmodule

// File: rtl/bwm_cnt.sv
module bwm_cnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         win_end,
  input  logic         clr,
  output logic [W-1:0] live,
  output logic [W-1:0] held
);
  function automatic logic [W-1:0] sat_inc(input logic [W-1:0] v);
    return (&v) ? v : v + W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      live <= '0;
      held <= '0;
    end else if (win_end) begin
      held <= live;
      live <= W'(inc);
    end else if (inc) begin
      live <= sat_inc(live);
    end
  end
endmodule

// File: rtl/bw_monitor.sv
module bw_monitor
  import bwm_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned TMR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [5:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [47:0]      port_req,
  input  logic [47:0]      port_gnt,
  output logic             irq
);
  logic                      mon_en, tmode, flag, win_end, win_active;
  logic                      req_any, gnt_any;
  logic [NCH-1:0]            ch_en, ch_hit;
  logic [NCH-1:0][MAJ-1:0]   pmask;
  logic [NCH-1:0][SUB-1:0]   smask;
  logic [TMR_W-1:0]          reload;
  logic [NCNT-1:0]           cnt_clr, cnt_inc;
  logic [NCNT-1:0][CNT_W-1:0] live_cnt, held_cnt;
  logic [DW-1:0]             rd_word;
  logic [WW-1:0]             word;

  bwm_regs #(.TMR_W(TMR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .win_end(win_end), .mon_en(mon_en), .tmode(tmode),
    .flag(flag), .ch_en(ch_en), .pmask(pmask), .smask(smask),
    .reload(reload), .cnt_clr(cnt_clr)
  );

  assign win_active = mon_en & tmode;

  bwm_window #(.TMR_W(TMR_W)) u_win (
    .clk(clk), .rst_n(rst_n), .active(win_active), .reload(reload),
    .win_end(win_end)
  );

  assign req_any    = |port_req;
  assign gnt_any    = |port_gnt;
  assign cnt_inc[0] = mon_en & req_any;
  assign cnt_inc[1] = mon_en & gnt_any;

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    assign ch_hit[n]      = chan_hit(port_gnt, pmask[n], smask[n]);
    assign cnt_inc[2 + n] = mon_en & ch_en[n] & ch_hit[n];
  end

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    bwm_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(cnt_inc[i]), .win_end(win_end),
      .clr(cnt_clr[i]), .live(live_cnt[i]), .held(held_cnt[i])
    );
  end

  assign word = bus_addr[AW-1:2];

  always_comb begin
    rd_word = '0;
    if (word == WW'(W_CTRL)) begin
      rd_word[B_EN]      = mon_en;
      rd_word[B_FLAG]    = flag;
      rd_word[B_TMODE]   = tmode;
      rd_word[NCH-1:0]   = ch_en;
    end
    if (word == WW'(W_TMR)) rd_word = DW'(reload);
    for (int n = 0; n < NCH; n++) begin
      if (word == WW'(W_FILT0 + 2 * n))     rd_word = pmask[n];
      if (word == WW'(W_FILT0 + 2 * n + 1)) rd_word = DW'(smask[n]);
    end
    for (int i = 0; i < NCNT; i++) begin
      if (word == WW'(W_CNT0 + i))
        rd_word = tmode ? DW'(held_cnt[i]) : DW'(live_cnt[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_word;
      irq <= flag & mon_en;
    end
  end
endmodule

// File: rtl/bwm_checker.sv
module bwm_checker
  import bwm_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       win_end,
  input logic                       mon_en,
  input logic                       flag,
  input logic                       irq,
  input logic                       gnt_any,
  input logic [NCNT-1:0]            cnt_clr,
  input logic [NCNT-1:0][CNT_W-1:0] live_cnt,
  input logic [NCNT-1:0][CNT_W-1:0] held_cnt
);
  a_r9_flag_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> flag);

  a_r10_irq_follows_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !flag |=> !irq);

  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en |=> !irq);

  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_end && !cnt_clr[0]) |=> (live_cnt[0] >= $past(live_cnt[0])));

  a_r8_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && !cnt_clr[1]) |=> (held_cnt[1] == $past(live_cnt[1])));

  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && !cnt_clr[1]) |=> (live_cnt[1] == CNT_W'($past(gnt_any))));
endmodule

bind bw_monitor bwm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .win_end(win_end), .mon_en(mon_en),
  .flag(flag), .irq(irq), .gnt_any(gnt_any), .cnt_clr(cnt_clr),
  .live_cnt(live_cnt), .held_cnt(held_cnt)
);

// File: tb/bw_monitor_tb.sv
`timescale 1ns/1ps
module bw_monitor_tb;
  localparam int CW = 8;
  localparam int TW = 16;
  localparam logic [CW-1:0] CMAX = '1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [47:0] port_req = '0, port_gnt = '0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bw_monitor #(.CNT_W(CW), .TMR_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .port_req(port_req), .port_gnt(port_gnt), .irq(irq)
  );

  // ---------------- bench cycle model ----------------
  logic          m_en, m_flag, m_tm, m_irq;
  logic [3:0]    m_ch;
  logic [31:0]   m_pm [4];
  logic [15:0]   m_sm [4];
  logic [TW-1:0] m_rl, m_tmr;
  logic [CW-1:0] m_live [6];
  logic [CW-1:0] m_held [6];
  logic [31:0]   m_rdata;

  function automatic logic m_hit(int n, logic [47:0] g);
    logic h = 1'b0;
    for (int p = 0; p < 48; p++) begin
      if (g[p]) begin
        if (p < 32) h |= m_pm[n][p];
        else        h |= m_pm[n][23] & m_sm[n][p-32];
      end
    end
    return h;
  endfunction

  function automatic logic [31:0] m_view(int w);
    logic [31:0] v = 32'h0;
    case (w)
      0:  v = {m_en, m_flag, 9'h0, m_tm, 16'h0, m_ch};
      1, 3, 5, 7: v = m_pm[(w-1)/2];
      2, 4, 6, 8: v = {16'h0, m_sm[(w-2)/2]};
      15: v = {16'h0, m_rl};
      default: v = {24'h0, m_tm ? m_held[w-9] : m_live[w-9]};
    endcase
    return v;
  endfunction

  always @(posedge clk) begin : mdl
    int w;
    logic act, we;
    logic [5:0] inc;
    if (!rst_n) begin
      m_en <= 0; m_flag <= 0; m_tm <= 0; m_irq <= 0; m_ch <= 0;
      m_rl <= 0; m_tmr <= 0; m_rdata <= 0;
      for (int i = 0; i < 4; i++) begin m_pm[i] <= 0; m_sm[i] <= 0; end
      for (int i = 0; i < 6; i++) begin m_live[i] <= 0; m_held[i] <= 0; end
    end else begin
      w   = int'(bus_addr[5:2]);
      act = m_en && m_tm;
      we  = act && (m_tmr == 0);
      inc[0] = m_en && (port_req != 0);
      inc[1] = m_en && (port_gnt != 0);
      for (int n = 0; n < 4; n++) inc[2+n] = m_en && m_ch[n] && m_hit(n, port_gnt);
      if (bus_rd) m_rdata <= m_view(w);
      for (int i = 0; i < 6; i++) begin
        if (bus_wr && w == 9 + i) begin m_live[i] <= 0; m_held[i] <= 0; end
        else if (we) begin m_held[i] <= m_live[i]; m_live[i] <= CW'(inc[i]); end
        else if (inc[i] && m_live[i] != CMAX) m_live[i] <= m_live[i] + 1;
      end
      if (!act || m_tmr == 0) m_tmr <= m_rl; else m_tmr <= m_tmr - 1;
      if (we) m_flag <= 1;
      else if (bus_wr && w == 0 && bus_wdata[30]) m_flag <= 0;
      m_irq <= m_flag && m_en;
      if (bus_wr) begin
        if (w == 0) begin
          m_en <= bus_wdata[31]; m_tm <= bus_wdata[20]; m_ch <= bus_wdata[3:0];
        end
        if (w >= 1 && w <= 8) begin
          if (w % 2 == 1) m_pm[(w-1)/2] <= bus_wdata;
          else            m_sm[(w-2)/2] <= bus_wdata[15:0];
        end
        if (w == 15) m_rl <= bus_wdata[TW-1:0];
      end
    end
  end

  // ---------------- tasks ----------------
  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rdchk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    check(tag, bus_rdata, exp);
  endtask

  function automatic logic [47:0] bit48(int p);
    return 48'(1) << p;
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    bit pend;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    check("R1 irq after reset", {31'h0, irq}, 32'h0);
    for (int w = 0; w < 16; w++) rdchk("R1 reset read", 6'(w * 4), 32'h0);

    // R4 / R3 / R12: free-running mode, major-port filter on channel 0
    wr(6'h04, 32'h0000_0020);
    wr(6'h00, 32'h8000_0001);
    rdchk("R1 control layout", 6'h00, 32'h8000_0001);
    port_gnt = bit48(5); port_req = bit48(5);
    repeat (3) @(negedge clk);
    port_gnt = bit48(6); port_req = bit48(1) | bit48(7);
    repeat (2) @(negedge clk);
    port_gnt = '0; port_req = '0;
    rdchk("R3 request total", 6'h24, 32'd5);
    rdchk("R3 grant total", 6'h28, 32'd5);
    rdchk("R4 channel 0 major match", 6'h2C, 32'd3);

    // R5 / R7 / R2: device subports, empty filter, disabled channel
    wr(6'h0C, 32'h0080_0000);
    wr(6'h10, 32'hFFFF_0004);
    wr(6'h1C, 32'hFFFF_FFFF);
    wr(6'h00, 32'h8000_0007);
    rdchk("R2 subport mask upper bits", 6'h10, 32'h0000_0004);
    rdchk("R2 port mask readback", 6'h1C, 32'hFFFF_FFFF);
    port_gnt = bit48(34); repeat (2) @(negedge clk);
    port_gnt = bit48(35); @(negedge clk);
    port_gnt = bit48(23); @(negedge clk);
    port_gnt = '0;
    rdchk("R5 device subport count", 6'h30, 32'd3);
    rdchk("R7 zero filters never match", 6'h34, 32'd0);
    rdchk("R7 channel enable clear", 6'h38, 32'd0);
    rdchk("R12 live view grant total", 6'h28, 32'd9);
    wr(6'h00, 32'h0000_000F);
    port_gnt = bit48(5); repeat (2) @(negedge clk); port_gnt = '0;
    rdchk("R7 global enable clear", 6'h2C, 32'd3);

    // R11: count write clears regardless of data
    wr(6'h2C, 32'h0000_1234);
    rdchk("R11 count write clears", 6'h2C, 32'd0);
    rdchk("R11 other count kept", 6'h28, 32'd9);

    // R6: saturation at 8 bits
    wr(6'h00, 32'h8000_0000);
    port_req = bit48(0); repeat (300) @(negedge clk); port_req = '0;
    rdchk("R6 saturation", 6'h24, 32'd255);

    // R8 / R9 / R10: timer windows
    wr(6'h00, 32'h0);
    for (int i = 0; i < 6; i++) wr(6'(36 + 4 * i), 32'h0);
    wr(6'h3C, 32'd9);
    wr(6'h00, 32'h8010_0001);
    port_gnt = bit48(5);
    repeat (10) @(negedge clk);
    check("R10 irq not yet", {31'h0, irq}, 32'h0);
    @(negedge clk);
    check("R10 irq one clock after flag", {31'h0, irq}, 32'h1);
    rdchk("R8 first window holds reload", 6'h2C, 32'd9);
    rdchk("R9 flag set", 6'h00, 32'hC010_0001);
    wr(6'h00, 32'hC010_0001);
    rdchk("R9 flag cleared by write back", 6'h00, 32'h8010_0001);
    check("R10 irq drops", {31'h0, irq}, 32'h0);
    repeat (6) @(negedge clk);
    rdchk("R8 later window holds reload+1", 6'h2C, 32'd10);
    rdchk("R12 held view grant total", 6'h28, 32'd10);
    port_gnt = '0;
    wr(6'h00, 32'h0);

    // random phase against the bench model (R8, R9, R10, R12)
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1;
    pend = 0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      int op;
      if (pend) check("R12 random read vs model", bus_rdata, m_rdata);
      check("R10 random irq vs model", {31'h0, irq}, {31'h0, m_irq});
      bus_wr = 0; bus_rd = 0; pend = 0;
      port_req = {16'($urandom), 32'($urandom)} & {16'($urandom), 32'($urandom)};
      port_gnt = ($urandom % 3 == 0) ? bit48(int'($urandom % 48)) : '0;
      op = int'($urandom % 16);
      if (op < 4) begin
        bus_rd = 1; bus_addr = 6'(($urandom % 16) * 4); pend = 1;
      end else if (op == 4) begin
        bus_wr = 1; bus_addr = 6'h00;
        bus_wdata = {($urandom % 8 != 0), 1'($urandom), 9'h0, 1'($urandom), 16'h0, 4'($urandom)};
      end else if (op == 5) begin
        bus_wr = 1; bus_addr = 6'h3C; bus_wdata = $urandom % 12;
      end else if (op == 6) begin
        bus_wr = 1; bus_addr = 6'(($urandom % 8 + 1) * 4);
        bus_wdata = ($urandom % 2 == 0) ? 32'(bit48(int'($urandom % 32))) | 32'h0080_0000
                                        : $urandom;
      end else if (op == 7 && ($urandom % 8 == 0)) begin
        bus_wr = 1; bus_addr = 6'(36 + 4 * ($urandom % 6)); bus_wdata = $urandom;
      end
      @(negedge clk);
    end
    if (pend) check("R12 random read vs model", bus_rdata, m_rdata);

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule